// File: doc/BRIEF.md
# Iterative 64-bit Integer Divide and Remainder Unit

This unit performs integer division for a 64-bit processor pipeline. A caller presents a dividend, a divisor and four control bits together with a request strobe that is high for one cycle. The unit works through the quotient one bit per clock. It then presents a 64-bit write-back value and raises a response strobe for exactly one cycle. While a division is in flight, further request strobes have no effect.

Four control bits select the operation. `req_signed` chooses two's-complement or unsigned operands. `req_word` chooses 32-bit operands taken from the low halves of the inputs. `req_ext` chooses an extended dividend, which is the dividend shifted up by the operand width. `req_rem` chooses the remainder in place of the quotient. Every case with no defined answer returns zero: a zero divisor, a signed quotient that does not fit, and an extended quotient that overflows. A caller therefore never needs a separate fix-up path.

Top module: `div_unit`

## Requirements
- R1: After reset `resp_valid` and `resp_data` are 0. After a request is accepted on a clock edge, `resp_valid` is high during the cycle that follows the 65th clock edge after the accepting edge (W+1 with W=64), and it is high for exactly one cycle.
- R2: A request raised in the same cycle that `resp_valid` is high is accepted. It produces its own correct result with the same latency and the same one-cycle strobe.
- R3: With `req_signed`=0, `req_word`=0 and `req_ext`=0, the result is the unsigned quotient. When `req_rem`=1 it is the unsigned remainder instead.
- R4: With `req_signed`=1 and 64-bit operands, the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R5: A zero divisor gives a result of 0 for every operation. In word mode, a divisor is zero when its low 32 bits are zero.
- R6: A signed quotient that does not fit returns 0. This covers the most negative 64-bit value divided by -1, and the most negative 32-bit word divided by -1 in word mode.
- R7: In 64-bit extended mode (`req_ext`=1, `req_rem`=0), the dividend is `req_a`·2^64. An unsigned result is 0 unless `req_b` > `req_a`. A signed result is 0 unless the quotient fits in 64 signed bits.
- R8: In word quotient mode, only the low 32 bits of each operand are used. The 32-bit quotient is returned with the upper 32 result bits zero.
- R9: The word remainder in signed mode is sign-extended to 64 bits. In unsigned mode it is zero-extended.
- R10: In word extended mode, the dividend is `req_a[31:0]`·2^32 and the divisor is `req_b[31:0]`. An unsigned result is 0 unless `req_b[31:0]` > `req_a[31:0]`. A signed result is 0 unless the quotient fits in 32 signed bits, and a result that fits is zero-extended.
- R11: A request strobe while a division is in flight is ignored. The in-flight result is unchanged and no extra response appears.
- R12: `req_ext` has no effect when `req_rem`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_a | input | 64 | Dividend |
| req_b | input | 64 | Divisor |
| req_signed | input | 1 | 1 = two's-complement operands |
| req_word | input | 1 | 1 = 32-bit operands from the low halves |
| req_ext | input | 1 | 1 = extended dividend (quotient only) |
| req_rem | input | 1 | 1 = return remainder |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_data | output | 64 | Write-back value |

## Verification
A vector table walks every combination of sign, width, extension and remainder. It uses operands with mixed signs so that truncation toward zero is distinguished from flooring, and so that the sign rule for the remainder is distinguished from the sign rule for the quotient. Word-mode vectors put unrelated values in the upper operand halves, which shows that those halves are ignored. The extended vectors sit on both sides of the fit limit: a divisor equal to the dividend, just above it, and quotients of exactly 2^63 or 2^31 with either sign. These show whether the positive and negative fit bounds are handled separately. Directed sequences measure latency, strobe width, a back-to-back issue and a request raised mid-division.

// File: rtl/div_pkg.sv
// Shared types for the iterative divider.
package div_pkg;
    // Operation selection carried from request to result fix-up.
    typedef struct packed {
        logic sgn;   // two's-complement operands
        logic word;  // 32-bit operands in the low halves
        logic ext;   // extended dividend (ignored for remainder)
        logic rem;   // return remainder instead of quotient
    } div_ctl_t;
endpackage

// File: rtl/div_prep.sv
// Operand preparation: turns the request into magnitudes and a
// double-width numerator {n_hi, n_lo} for an unsigned engine.
// Assumes W is even. pre_ovf flags a numerator whose high half is not
// below the divisor (zero divisor or extended overflow).
module div_prep
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  div_ctl_t     ctl,
    output logic [W-1:0] n_hi,
    output logic [W-1:0] n_lo,
    output logic [W-1:0] d,
    output logic         q_neg,
    output logic         r_neg,
    output logic         pre_ovf
);
    localparam int HW = W / 2;

    logic          sa, sb, use_ext;
    logic [W-1:0]  a_mag, b_mag;
    logic [HW-1:0] a_lo_neg, b_lo_neg;

    // Sign extraction, magnitude and numerator placement.
    always_comb begin
        sa       = ctl.sgn & (ctl.word ? a[HW-1] : a[W-1]);
        sb       = ctl.sgn & (ctl.word ? b[HW-1] : b[W-1]);
        a_lo_neg = ~a[HW-1:0] + 1'b1;
        b_lo_neg = ~b[HW-1:0] + 1'b1;
        if (ctl.word) begin
            a_mag = {{HW{1'b0}}, (sa ? a_lo_neg : a[HW-1:0])};
            b_mag = {{HW{1'b0}}, (sb ? b_lo_neg : b[HW-1:0])};
        end else begin
            a_mag = sa ? (~a + 1'b1) : a;
            b_mag = sb ? (~b + 1'b1) : b;
        end
        use_ext = ctl.ext & ~ctl.rem;
        n_hi    = (use_ext && !ctl.word) ? a_mag : '0;
        if (use_ext)
            n_lo = ctl.word ? {a_mag[HW-1:0], {HW{1'b0}}} : '0;
        else
            n_lo = a_mag;
        d       = b_mag;
        pre_ovf = (n_hi >= d);
        q_neg   = sa ^ sb;
        r_neg   = sa;
    end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract engine: one quotient bit per clock, W steps.
// Assumes n_hi < d at start (the caller discards results otherwise) and
// W a power of two. start is ignored while busy.
module div_core #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] n_hi,
    input  logic [W-1:0] n_lo,
    input  logic [W-1:0] d,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  d_q;
    logic [CW-1:0] cnt;
    logic [W:0]    sh;
    logic [W-1:0]  diff;
    logic          take;

    // One trial subtraction of the shifted partial remainder.
    always_comb begin
        sh   = {rem, quo[W-1]};
        take = (sh >= {1'b0, d_q});
        diff = sh[W-1:0] - d_q;
    end

    // Load on start, then step until W quotient bits are produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            quo  <= '0;
            rem  <= '0;
            d_q  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem  <= n_hi;
                quo  <= n_lo;
                d_q  <= d;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                rem <= take ? diff : sh[W-1:0];
                quo <= {quo[W-2:0], take};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> cnt == $past(cnt) + 1'b1);
    // R1
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy || done);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/div_fix.sv
// Result fix-up: applies signs, checks that the quotient fits the
// selected width and forms the 64-bit write-back value. Purely
// combinational; assumes quo/rem are unsigned magnitudes.
module div_fix
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  div_ctl_t     ctl,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         pre_ovf,
    output logic [W-1:0] result
);
    localparam int           HW      = W / 2;
    localparam logic [W-1:0] HALF_W  = W'(1) << (W - 1);
    localparam logic [W-1:0] HALF_HW = W'(1) << (HW - 1);

    logic [W-1:0] qv, rv, q_lim;
    logic         q_fit;

    // Sign application, fit test and width shaping.
    always_comb begin
        qv    = q_neg ? (~quo + 1'b1) : quo;
        rv    = r_neg ? (~rem + 1'b1) : rem;
        q_lim = ctl.word ? HALF_HW : HALF_W;
        if (!ctl.sgn)
            q_fit = ctl.word ? (quo[W-1:HW] == '0) : 1'b1;
        else
            q_fit = q_neg ? (quo <= q_lim) : (quo < q_lim);
        result = '0;
        if (!pre_ovf) begin
            if (ctl.rem) begin
                if (ctl.word)
                    result = {{HW{ctl.sgn & rv[HW-1]}}, rv[HW-1:0]};
                else
                    result = rv;
            end else if (q_fit) begin
                result = ctl.word ? {{HW{1'b0}}, qv[HW-1:0]} : qv;
            end
        end
    end
endmodule

// File: rtl/div_unit.sv
// Top of the iterative divider. Accepts a request when idle, holds the
// operation controls for the result stage and registers the write-back
// value with a one-cycle strobe. Assumes req_valid is a one-cycle pulse.
module div_unit
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] req_a,
    input  logic [W-1:0] req_b,
    input  logic         req_signed,
    input  logic         req_word,
    input  logic         req_ext,
    input  logic         req_rem,
    output logic         resp_valid,
    output logic [W-1:0] resp_data
);
    localparam int HW = W / 2;

    div_ctl_t     ctl_in, ctl_q;
    logic [W-1:0] n_hi, n_lo, d, quo, rem, fixed;
    logic         q_neg, r_neg, pre_ovf;
    logic         q_neg_q, r_neg_q, ovf_q;
    logic         busy, done, accept, zdiv, zdiv_q, zdiv_out;

    assign ctl_in = '{sgn: req_signed, word: req_word, ext: req_ext, rem: req_rem};
    assign accept = req_valid && !busy;
    assign zdiv   = req_word ? (req_b[HW-1:0] == '0) : (req_b == '0);

    div_prep #(.W(W)) u_prep (
        .a(req_a), .b(req_b), .ctl(ctl_in),
        .n_hi(n_hi), .n_lo(n_lo), .d(d),
        .q_neg(q_neg), .r_neg(r_neg), .pre_ovf(pre_ovf)
    );

    div_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(req_valid),
        .n_hi(n_hi), .n_lo(n_lo), .d(d),
        .busy(busy), .done(done), .quo(quo), .rem(rem)
    );

    div_fix #(.W(W)) u_fix (
        .quo(quo), .rem(rem), .ctl(ctl_q),
        .q_neg(q_neg_q), .r_neg(r_neg_q), .pre_ovf(ovf_q),
        .result(fixed)
    );

    // Hold the accepted request's controls until its result is formed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            q_neg_q <= 1'b0;
            r_neg_q <= 1'b0;
            ovf_q   <= 1'b0;
            zdiv_q  <= 1'b0;
        end else if (accept) begin
            ctl_q   <= ctl_in;
            q_neg_q <= q_neg;
            r_neg_q <= r_neg;
            ovf_q   <= pre_ovf;
            zdiv_q  <= zdiv;
        end
    end

    // Register the write-back value and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            zdiv_out   <= 1'b0;
        end else begin
            resp_valid <= done;
            if (done) begin
                resp_data <= fixed;
                zdiv_out  <= zdiv_q;
            end
        end
    end

    // R1
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && zdiv_out |-> resp_data == '0);
endmodule

// File: tb/sim_div_unit.sv
module sim_div_unit;
    localparam int LAT = 65;  // R1: W+1 edges from the accepting edge

    typedef struct packed {
        logic [3:0]  ctl;  // {signed, word, ext, rem}
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] e;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{4'b0000, 64'd100, 64'd7, 64'd14},
        '{4'b0001, 64'd100, 64'd7, 64'd2},
        '{4'b0000, 64'h1000_0111, 64'h1111, 64'hF001},
        '{4'b1000, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFF2},
        '{4'b1001, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE},
        '{4'b1000, 64'd100, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFF2},
        '{4'b1001, 64'd100, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2},
        '{4'b1000, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3},
        '{4'b1001, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF},
        '{4'b1000, 64'h8000_0000_0000_0000, 64'd1, 64'h8000_0000_0000_0000},
        '{4'b1000, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},
        '{4'b1100, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},
        '{4'b0000, 64'd5, 64'd0, 64'd0},
        '{4'b1001, 64'd5, 64'd0, 64'd0},
        '{4'b0110, 64'd1, 64'hFFFF_FFFF_0000_0000, 64'd0},
        '{4'b0010, 64'd1, 64'd2, 64'h8000_0000_0000_0000},
        '{4'b0010, 64'd2, 64'd2, 64'd0},
        '{4'b0010, 64'd1, 64'd3, 64'h5555_5555_5555_5555},
        '{4'b1010, 64'd1, 64'd4, 64'h4000_0000_0000_0000},
        '{4'b1010, 64'd1, 64'd2, 64'd0},
        '{4'b1010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h8000_0000_0000_0000},
        '{4'b0100, 64'hFFFF_FFFF_0000_0064, 64'hAAAA_AAAA_0000_0007, 64'hE},
        '{4'b1100, 64'h0000_0000_FFFF_FF9C, 64'd7, 64'h0000_0000_FFFF_FFF2},
        '{4'b1101, 64'h0000_0000_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE},
        '{4'b0101, 64'h1234_5678_FFFF_FFFF, 64'h10, 64'hF},
        '{4'b1101, 64'd100, 64'h0000_0000_FFFF_FFF9, 64'd2},
        '{4'b0110, 64'd1, 64'd2, 64'h0000_0000_8000_0000},
        '{4'b0110, 64'd2, 64'd2, 64'd0},
        '{4'b0110, 64'hFFFF_FFFF_0000_0001, 64'd3, 64'h0000_0000_5555_5555},
        '{4'b1110, 64'd1, 64'd4, 64'h0000_0000_4000_0000},
        '{4'b1110, 64'd1, 64'd2, 64'd0},
        '{4'b1110, 64'h0000_0000_FFFF_FFFF, 64'd2, 64'h0000_0000_8000_0000},
        '{4'b0011, 64'd100, 64'd7, 64'd2},
        '{4'b0111, 64'd100, 64'd7, 64'd2}
    };
    localparam string TAGS [NV] = '{
        "R3", "R3", "R3", "R4", "R4", "R4", "R4", "R4", "R4", "R4",
        "R6", "R6", "R5", "R5", "R5", "R7", "R7", "R7", "R7", "R7",
        "R7", "R8", "R8", "R9", "R9", "R9", "R10", "R10", "R10", "R10",
        "R10", "R10", "R12", "R12"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_a = '0, req_b = '0;
    logic        req_signed = 1'b0, req_word = 1'b0, req_ext = 1'b0, req_rem = 1'b0;
    logic        resp_valid;
    logic [63:0] resp_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    div_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_a(req_a), .req_b(req_b),
        .req_signed(req_signed), .req_word(req_word),
        .req_ext(req_ext), .req_rem(req_rem),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [63:0] a, input logic [63:0] b);
        {req_signed, req_word, req_ext, req_rem} = ctl;
        req_a = a;
        req_b = b;
        req_valid = 1'b1;
    endtask

    // Called at a negedge: issue, then wait for the response strobe.
    task automatic run_op(input logic [3:0] ctl, input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] data, output int lat);
        drive(ctl, a, b);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        data = resp_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] data;
        int lat;
        int extra;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset resp_valid", {63'd0, resp_valid}, 64'd0);
        chk("R1 reset resp_data", resp_data, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle resp_valid", {63'd0, resp_valid}, 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i].ctl, TBL[i].a, TBL[i].b, data, lat);
            chk(TAGS[i], data, TBL[i].e);
            @(negedge clk);
            chk("R1 pulse width", {63'd0, resp_valid}, 64'd0);
        end

        // R1 latency
        run_op(4'b0000, 64'd1000, 64'd10, data, lat);
        chk("R1 latency", 64'(lat), 64'(LAT));
        chk("R3 1000/10", data, 64'd100);

        // R2 back-to-back: issue in the cycle resp_valid is high
        run_op(4'b1000, 64'hFFFF_FFFF_FFFF_FC18, 64'd10, data, lat);
        chk("R2 first value", data, 64'hFFFF_FFFF_FFFF_FF9C);
        run_op(4'b0001, 64'd1001, 64'd10, data, lat);
        chk("R2 second value", data, 64'd1);
        chk("R2 second latency", 64'(lat), 64'(LAT));
        @(negedge clk);
        chk("R2 second pulse width", {63'd0, resp_valid}, 64'd0);

        // R11: request mid-division is ignored
        drive(4'b0000, 64'd100, 64'd7);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        repeat (5) begin
            @(posedge clk);
            lat++;
        end
        @(negedge clk);
        drive(4'b0001, 64'd555, 64'd0);
        @(posedge clk);
        lat++;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R11 in-flight value", resp_data, 64'd14);
        chk("R11 in-flight latency", 64'(lat), 64'(LAT));
        extra = 0;
        repeat (80) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        chk("R11 no extra response", 64'(extra), 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule